// File: doc/BRIEF.md
# Constant On-Time Switching Sequencer

This block is the digital heart of a constant on-time step-down converter controller. It reads three comparator results that have already been digitized and synchronized to its clock: feedback below reference, inductor current zero crossing, and valley over-current. From these it drives two gate enables, one for the high-side switch and one for the low-side switch. No oscillator is involved. Each switching cycle opens with a high-side pulse whose length is a programmed clock count. A guaranteed off interval follows. The next cycle begins only once feedback has dropped below the reference and the valley current is within its limit.

Under light load the sequencer moves into pulse-frequency operation. It turns the low-side switch off at each zero crossing, but only after an unbroken run of switching cycles that each showed a crossing. When the output sits idle too long, a minimum-frequency watchdog forces a short low-side discharge pulse and then starts a fresh cycle. During soft-start two inputs let the surrounding logic disable that watchdog and force light-load behaviour. A programmed on-time that reads as a floating programming pin stops all switching. The dead-time shaping, the gate drivers and the analog comparators are outside this block.

Top module: `cot_sequencer`

## Requirements
- R1: Every high-side pulse lasts exactly `ton_count` clock cycles, using the value sampled when the cycle starts. A pulse is cut short only by `enable` going low or by a configuration fault.
- R2: Between two high-side pulses the high-side enable stays low for at least MIN_OFF clock cycles. When `fb_low` is held high, the low interval is exactly MIN_OFF cycles.
- R3: After the off interval, a new high-side pulse starts only while `fb_low` is high. When `fb_low` is held high the switching period is `ton_count` + MIN_OFF cycles. While `fb_low` is low, no pulse starts and the low-side enable stays on.
- R4: While `valley_oc` is high, no high-side pulse starts and the low-side enable stays on. Once it clears, the high-side pulse follows two cycles later: one idle cycle, then high-side on.
- R5: Outside forced light-load mode, `zero_cross` has no effect until ZC_RUN (default 9) completed switching cycles have each seen a crossing while the high side was off. From then on, `light_mode` reads 1, and a crossing seen in the low-side-on state turns the low-side enable off on the next cycle.
- R6: A completed switching cycle without any zero crossing resets the crossing run to zero, so `light_mode` falls to 0 at the next cycle start.
- R7: If no cycle has started for MINF_PERIOD cycles while the sequencer is in its low-side-on or coasting state, the low-side enable is driven on for DISCH_CYC cycles. One idle cycle follows, then a high-side pulse, so the period is MINF_PERIOD + DISCH_CYC + 1 cycles.
- R8: While `minf_disable` is high, no discharge pulse and no forced cycle occur.
- R9: While `force_light` is high, `light_mode` reads 1 and zero crossings turn the low-side enable off right from the first cycle.
- R10: A `ton_count` of all zeros or all ones is an open-pin fault. `cfg_fault` rises one cycle later and both enables stay low until the value is valid again.
- R11: The two enables are never high in the same cycle, and every change from one to the other passes through at least one cycle with both low.
- R12: Both enables are low during reset, and from the cycle after `enable` goes low. A low-side enable is never raised before the first high-side pulse after enabling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| enable | input | 1 | Run request; low forces both switches off |
| fb_low | input | 1 | Feedback below reference |
| zero_cross | input | 1 | Inductor current has reached zero |
| valley_oc | input | 1 | Valley current above the limit |
| ton_count | input | CNT_W | High-side on-time in clock cycles |
| minf_disable | input | 1 | Suppress the minimum-frequency discharge |
| force_light | input | 1 | Force light-load (zero-crossing) behaviour |
| hs_on | output | 1 | High-side gate enable |
| ls_on | output | 1 | Low-side gate enable |
| light_mode | output | 1 | Light-load zero-crossing turn-off active |
| cfg_fault | output | 1 | On-time configuration reads as an open pin |

## Verification
The bench builds the sequencer with an 8-bit on-time, a 4-cycle minimum off time, a 60-cycle minimum-frequency period and a 3-cycle discharge pulse, while keeping the default run of nine crossings. The short off time and watchdog period let a discharge, its follow-on cycle and a full ten-cycle light-load entry sequence fit in a few hundred clock cycles. The 8-bit on-time makes the all-ones fault code reachable as 255.

// File: rtl/cot_pkg.sv
package cot_pkg;

  // Sequencer phases; each phase fixes which gate enable may be high.
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,  // both off, waiting for a first cycle
    ST_HS     = 3'd1,  // high-side on-time running
    ST_GAP_LS = 3'd2,  // idle cycle before the low side turns on
    ST_LS     = 3'd3,  // low side conducting, off interval
    ST_COAST  = 3'd4,  // both off after a light-load zero crossing
    ST_GAP_HS = 3'd5,  // idle cycle before the high side turns on
    ST_DISCH  = 3'd6   // forced low-side discharge pulse
  } cot_state_e;

endpackage

// File: rtl/cot_pulse_timer.sv
// Loadable down-counter; 'last' marks the final cycle of a loaded count.
module cot_pulse_timer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         last
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (tick && (cnt_q != '0)) begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q == W'(1));

endmodule

// File: rtl/cot_offtime_guard.sv
// Counts cycles with the high side off, saturating at MIN_OFF.
module cot_offtime_guard #(
  parameter int MIN_OFF = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_on,
  output logic ok_direct,  // next-cycle high side meets the off time
  output logic ok_gap      // high side two cycles later meets it
);

  localparam int W = $clog2(MIN_OFF + 1);
  localparam logic [W-1:0] SAT   = W'(MIN_OFF);
  localparam logic [W-1:0] THR_D = W'(MIN_OFF - 1);
  localparam logic [W-1:0] THR_G = W'(MIN_OFF - 2);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (hs_on) begin
      cnt_d = '0;
    end else if (cnt_q != SAT) begin
      cnt_d = cnt_q + W'(1);
    end
  end

  // Out of reset the off time counts as already served.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= SAT;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign ok_direct = (cnt_q >= THR_D);
  assign ok_gap    = (cnt_q >= THR_G);

endmodule

// File: rtl/cot_zc_tracker.sv
// Counts consecutive switching cycles that contained a zero crossing.
module cot_zc_tracker #(
  parameter int ZC_RUN = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,        // sequencer idle: forget history
  input  logic cycle_start,  // a new high-side pulse begins
  input  logic zc_sample,    // crossing seen while high side off
  output logic run_full
);

  localparam int W = $clog2(ZC_RUN + 1);
  localparam logic [W-1:0] FULL = W'(ZC_RUN);

  logic [W-1:0] run_q, run_d;
  logic         seen_q, seen_d;
  logic         armed_q, armed_d;
  logic         hit;

  assign hit = seen_q | zc_sample;

  always_comb begin
    run_d   = run_q;
    seen_d  = seen_q;
    armed_d = armed_q;
    if (cycle_start) begin
      seen_d  = 1'b0;
      armed_d = 1'b1;
      if (armed_q) begin
        if (!hit) begin
          run_d = '0;
        end else if (run_q != FULL) begin
          run_d = run_q + W'(1);
        end
      end
    end else if (clear) begin
      run_d   = '0;
      seen_d  = 1'b0;
      armed_d = 1'b0;
    end else if (zc_sample) begin
      seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      seen_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      seen_q  <= seen_d;
      armed_q <= armed_d;
    end
  end

  assign run_full = (run_q == FULL);

endmodule

// File: rtl/cot_minfreq_watch.sv
// Cycles since the last cycle start; flags when the period has elapsed.
module cot_minfreq_watch #(
  parameter int MINF_PERIOD = 13889
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cycle_start,
  output logic expired
);

  localparam int W = $clog2(MINF_PERIOD);
  localparam logic [W-1:0] LIM = W'(MINF_PERIOD - 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (cycle_start) begin
      cnt_d = '0;
    end else if (cnt_q != LIM) begin
      cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == LIM);

endmodule

// File: rtl/cot_sequencer.sv
// Constant on-time switching sequencer: gate-enable phase control.
module cot_sequencer
  import cot_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int MIN_OFF     = 80,     // >= 3 cycles
  parameter int MINF_PERIOD = 13889,
  parameter int DISCH_CYC   = 50,     // >= 1 cycle
  parameter int ZC_RUN      = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             fb_low,
  input  logic             zero_cross,
  input  logic             valley_oc,
  input  logic [CNT_W-1:0] ton_count,
  input  logic             minf_disable,
  input  logic             force_light,
  output logic             hs_on,
  output logic             ls_on,
  output logic             light_mode,
  output logic             cfg_fault
);

  localparam int DW = $clog2(DISCH_CYC + 1);
  localparam logic [CNT_W-1:0] OPEN_HI = {CNT_W{1'b1}};

  cot_state_e state_q, state_d;

  logic bad_cfg, go_live;
  logic ton_last, disch_last;
  logic off_ok_direct, off_ok_gap;
  logic run_full, minf_expired, clamp_fire;
  logic cycle_start, disch_enter, zc_sample;
  logic hs_d, ls_d;

  assign bad_cfg    = (ton_count == '0) || (ton_count == OPEN_HI);
  assign go_live    = enable && !bad_cfg;
  assign light_mode = force_light || run_full;
  assign clamp_fire = !minf_disable && minf_expired;

  // ---------------- next phase ----------------
  always_comb begin
    state_d = state_q;
    if (!go_live) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (fb_low && !valley_oc && off_ok_direct) state_d = ST_HS;
        end
        ST_HS: begin
          if (ton_last) state_d = ST_GAP_LS;
        end
        ST_GAP_LS: state_d = ST_LS;
        ST_LS: begin
          if (clamp_fire) begin
            state_d = ST_DISCH;
          end else if (fb_low && !valley_oc && off_ok_gap) begin
            state_d = ST_GAP_HS;
          end else if (light_mode && zero_cross && !valley_oc) begin
            state_d = ST_COAST;
          end
        end
        ST_COAST: begin
          if (valley_oc) begin
            state_d = ST_LS;
          end else if (clamp_fire) begin
            state_d = ST_DISCH;
          end else if (fb_low && off_ok_direct) begin
            state_d = ST_HS;
          end
        end
        ST_GAP_HS: begin
          state_d = valley_oc ? ST_LS : ST_HS;
        end
        ST_DISCH: begin
          if (disch_last) state_d = valley_oc ? ST_LS : ST_GAP_HS;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  assign cycle_start = (state_d == ST_HS) && (state_q != ST_HS);
  assign disch_enter = (state_d == ST_DISCH) && (state_q != ST_DISCH);
  assign zc_sample   = zero_cross && (state_q != ST_HS);
  assign hs_d        = (state_d == ST_HS);
  assign ls_d        = (state_d == ST_LS) || (state_d == ST_DISCH);

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      hs_on     <= 1'b0;
      ls_on     <= 1'b0;
      cfg_fault <= 1'b0;
    end else begin
      state_q   <= state_d;
      hs_on     <= hs_d;
      ls_on     <= ls_d;
      cfg_fault <= bad_cfg;
    end
  end

  // ---------------- helpers ----------------
  cot_pulse_timer #(.W(CNT_W)) u_ton_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cycle_start),
    .load_val (ton_count),
    .tick     (state_q == ST_HS),
    .last     (ton_last)
  );

  cot_pulse_timer #(.W(DW)) u_disch_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (disch_enter),
    .load_val (DW'(DISCH_CYC)),
    .tick     (state_q == ST_DISCH),
    .last     (disch_last)
  );

  cot_offtime_guard #(.MIN_OFF(MIN_OFF)) u_off_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .hs_on     (hs_on),
    .ok_direct (off_ok_direct),
    .ok_gap    (off_ok_gap)
  );

  cot_zc_tracker #(.ZC_RUN(ZC_RUN)) u_zc_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (state_q == ST_IDLE),
    .cycle_start (cycle_start),
    .zc_sample   (zc_sample),
    .run_full    (run_full)
  );

  cot_minfreq_watch #(.MINF_PERIOD(MINF_PERIOD)) u_minf (
    .clk         (clk),
    .rst_n       (rst_n),
    .cycle_start (cycle_start),
    .expired     (minf_expired)
  );

endmodule

// File: rtl/cot_sequencer_checks.sv
// Port-level properties of the sequencer, attached by bind.
module cot_sequencer_checks #(
  parameter int CNT_W   = 10,
  parameter int MIN_OFF = 80
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             valley_oc,
  input logic [CNT_W-1:0] ton_count,
  input logic             hs_on,
  input logic             ls_on
);

  localparam int LW = $clog2(MIN_OFF + 1);
  localparam logic [LW-1:0] LSAT = LW'(MIN_OFF);

  logic [LW-1:0]    lo_run;
  logic [CNT_W:0]   hi_run;
  logic [CNT_W-1:0] ton_q, ton_lat;
  logic             hs_d;
  logic             open_cfg;

  assign open_cfg = (ton_count == '0) || (ton_count == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run  <= LSAT;
      hi_run  <= '0;
      ton_q   <= '0;
      ton_lat <= '0;
      hs_d    <= 1'b0;
    end else begin
      if (hs_on) lo_run <= '0;
      else if (lo_run != LSAT) lo_run <= lo_run + LW'(1);
      hi_run  <= hs_on ? hi_run + (CNT_W+1)'(1) : '0;
      ton_q   <= ton_count;
      hs_d    <= hs_on;
      if (hs_on && !hs_d) ton_lat <= ton_q;
    end
  end

  assert_ontime_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hs_on) && $past(enable) && !$past(open_cfg)) |-> (hi_run == {1'b0, ton_lat}));

  assert_min_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_on) |-> (lo_run >= LSAT));

  assert_oc_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_on) |-> !$past(valley_oc));

  assert_fault_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    open_cfg |=> (!hs_on && !ls_on));

  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on && ls_on));

  assert_gap_before_hs_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_on) |-> !$past(ls_on));

  assert_gap_before_ls_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_on) |-> !$past(hs_on));

  assert_disable_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!hs_on && !ls_on));

endmodule

bind cot_sequencer cot_sequencer_checks #(
  .CNT_W   (CNT_W),
  .MIN_OFF (MIN_OFF)
) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .valley_oc (valley_oc),
  .ton_count (ton_count),
  .hs_on     (hs_on),
  .ls_on     (ls_on)
);

// File: tb/tb_cot_sequencer.sv
module tb_cot_sequencer;

  localparam int CNT_W = 8;
  localparam int MINOFF = 4;
  localparam int MINF = 60;
  localparam int DISCH = 3;

  logic clk = 1'b0;
  logic rst_n, enable, fb_low, zero_cross, valley_oc;
  logic minf_disable, force_light;
  logic [CNT_W-1:0] ton_count;
  logic hs_on, ls_on, light_mode, cfg_fault;

  int checks = 0;
  int errors = 0;
  bit reported = 0;

  always #2 clk = ~clk;

  cot_sequencer #(
    .CNT_W(CNT_W), .MIN_OFF(MINOFF), .MINF_PERIOD(MINF),
    .DISCH_CYC(DISCH), .ZC_RUN(9)
  ) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fb_low(fb_low),
    .zero_cross(zero_cross), .valley_oc(valley_oc), .ton_count(ton_count),
    .minf_disable(minf_disable), .force_light(force_light),
    .hs_on(hs_on), .ls_on(ls_on), .light_mode(light_mode), .cfg_fault(cfg_fault)
  );

  // Port monitor: pulse widths, periods and gate overlap, sampled mid-cycle.
  int rises = 0, hi_len = 0, lo_len = 0, period = 0, ls_len = 0;
  int hi_run = 0, lo_run = 0, per_run = 0, ls_run = 0;
  int overlap = 0, gap_viol = 0;
  logic hs_q = 1'b0, ls_q = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (hs_on && ls_on) overlap++;
      if (hs_on && !hs_q && ls_q) gap_viol++;
      if (ls_on && !ls_q && hs_q) gap_viol++;
      if (hs_on && !hs_q) begin
        rises++; lo_len = lo_run; period = per_run; per_run = 1; hi_run = 1;
      end else begin
        per_run++;
        if (hs_on) hi_run++;
      end
      if (!hs_on && hs_q) begin hi_len = hi_run; lo_run = 1; end
      else if (!hs_on) lo_run++;
      if (ls_on) ls_run++;
      else if (ls_q) begin ls_len = ls_run; ls_run = 0; end
      hs_q = hs_on; ls_q = ls_on;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
  endtask

  task automatic wait_hs(input logic v, input string req);
    int n = 0;
    while (hs_on !== v && n < 300) begin @(negedge clk); n++; end
    if (n >= 300) chk({req, " hs wait timeout"}, 1, 0);
  endtask

  task automatic restart();
    enable = 1'b0; @(negedge clk); enable = 1'b1;
  endtask

  // One switching cycle kicked by fb_low; optional crossing in the low-side phase.
  task automatic run_cycle(input bit do_zc, input int exp_light,
                           input int exp_ls, input string req);
    fb_low = 1'b1;
    wait_hs(1'b1, req);
    chk({req, " light_mode at cycle start"}, light_mode, exp_light);
    fb_low = 1'b0;
    wait_hs(1'b0, req);
    @(negedge clk);
    if (do_zc) begin
      zero_cross = 1'b1;
      @(negedge clk);
      zero_cross = 1'b0;
      chk({req, " ls_on after crossing"}, ls_on, exp_ls);
    end
  endtask

  task automatic t_reset();
    chk("R12 reset hs_on", hs_on, 0);
    chk("R12 reset ls_on", ls_on, 0);
    chk("R12 reset light_mode", light_mode, 0);
    chk("R10 reset cfg_fault", cfg_fault, 0);
  endtask

  task automatic t_ccm();
    int n = 0;
    enable = 1'b1; fb_low = 1'b1;
    while (rises < 4 && n < 200) begin @(negedge clk); n++; end
    chk("R1 on-time 5", hi_len, 5);
    chk("R2 off interval", lo_len, MINOFF);
    chk("R3 period with fb held", period, 5 + MINOFF);
    ton_count = 8'd3;
    n = rises;
    while (rises < n + 2) @(negedge clk);
    chk("R1 on-time 3", hi_len, 3);
    chk("R3 period with on-time 3", period, 3 + MINOFF);
    ton_count = 8'd5;
  endtask

  task automatic t_fb_wait();
    int r;
    minf_disable = 1'b1;
    wait_hs(1'b1, "R3");
    fb_low = 1'b0;
    wait_hs(1'b0, "R3");
    r = rises;
    repeat (30) @(negedge clk);
    chk("R3 no pulse while fb high", rises, r);
    chk("R3 low side holds", ls_on, 1);
    fb_low = 1'b1;
    @(negedge clk);
    chk("R3 idle cycle hs", hs_on, 0);
    chk("R11 idle cycle ls", ls_on, 0);
    @(negedge clk);
    chk("R3 restart hs", hs_on, 1);
  endtask

  task automatic t_oc();
    int bad = 0;
    fb_low = 1'b1;
    wait_hs(1'b1, "R4");
    fb_low = 1'b0;
    wait_hs(1'b0, "R4");
    @(negedge clk);
    valley_oc = 1'b1; fb_low = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (hs_on || !ls_on) bad++;
    end
    chk("R4 blocked cycles", bad, 0);
    valley_oc = 1'b0;
    @(negedge clk);
    chk("R4 idle cycle after clear", hs_on | ls_on, 0);
    @(negedge clk);
    chk("R4 hs after clear", hs_on, 1);
    fb_low = 1'b0;
  endtask

  task automatic t_zc_run();
    wait_hs(1'b0, "R5");
    restart();
    for (int c = 1; c <= 10; c++) begin
      run_cycle(1'b1, (c == 10) ? 1 : 0, (c == 10) ? 0 : 1, "R5");
    end
    run_cycle(1'b0, 1, 1, "R6 cycle without crossing");
    run_cycle(1'b1, 0, 1, "R6 run cleared");
  endtask

  task automatic t_force();
    restart();
    force_light = 1'b1;
    run_cycle(1'b1, 1, 0, "R9");
  endtask

  task automatic t_clamp();
    int r, n = 0;
    restart();
    minf_disable = 1'b0;
    run_cycle(1'b1, 1, 0, "R7 kick");
    r = rises;
    while (rises == r && n < 200) begin @(negedge clk); n++; end
    chk("R7 forced period", period, MINF + DISCH + 1);
    chk("R7 discharge length", ls_len, DISCH);
    minf_disable = 1'b1;
    wait_hs(1'b0, "R8");
    repeat (3) @(negedge clk);
    zero_cross = 1'b1; @(negedge clk); zero_cross = 1'b0;
    r = rises;
    repeat (200) @(negedge clk);
    chk("R8 no forced cycle", rises, r);
    chk("R8 no discharge", ls_on, 0);
    force_light = 1'b0;
  endtask

  task automatic t_fault();
    int bad = 0;
    minf_disable = 1'b0;
    fb_low = 1'b1;
    ton_count = 8'd0;
    repeat (2) @(negedge clk);
    chk("R10 fault on zero", cfg_fault, 1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); if (hs_on || ls_on) bad++;
    end
    ton_count = 8'hFF;
    repeat (2) @(negedge clk);
    chk("R10 fault on all ones", cfg_fault, 1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); if (hs_on || ls_on) bad++;
    end
    chk("R10 switching held off", bad, 0);
    ton_count = 8'd5;
    wait_hs(1'b1, "R10");
    chk("R10 fault clears", cfg_fault, 0);
  endtask

  task automatic t_enable();
    int bad = 0;
    wait_hs(1'b1, "R12");
    enable = 1'b0;
    @(negedge clk);
    chk("R12 hs off after disable", hs_on, 0);
    chk("R12 ls off after disable", ls_on, 0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); if (hs_on || ls_on) bad++;
    end
    chk("R12 stays off", bad, 0);
    enable = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; fb_low = 1'b0; zero_cross = 1'b0;
    valley_oc = 1'b0; minf_disable = 1'b0; force_light = 1'b0;
    ton_count = 8'd5;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_ccm();
    t_fb_wait();
    t_oc();
    t_zc_run();
    t_force();
    t_clamp();
    t_fault();
    t_enable();
    repeat (20) @(negedge clk);
    chk("R11 overlap cycles", overlap, 0);
    chk("R11 missing idle cycles", gap_viol, 0);
    report();
    $finish;
  end

endmodule